// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

The block turns a single burst request into the series of word addresses that a synchronous burst read of a NOR-style array fetches. A small configuration register holds a burst-length code and a launch-edge select bit. When a burst is requested, the block captures the start address. It then steps the low address bits through an aligned group of 8 or 16 words, starting at the requested offset and wrapping back to the start of the group. The upper address bits do not change during the burst.

A one-cycle wait indication comes before the first word. A valid strobe marks each issued word, and a done flag follows the last word. All outputs can be launched on the rising clock edge, which is the default, or half a cycle later on the falling edge. Dropping the enable input abandons a burst at once.

Top module: `wrap_burst_seq`

## Requirements
- R1: After a synchronous reset, `word_addr`, `data_valid`, `burst_wait` and `burst_done` are all 0. The configuration defaults to an 8-word burst launched on the rising edge.
- R2: Length code 3'b010 gives an 8-word burst. Word i has address bits [2:0] equal to (start[2:0] + i) mod 8, and bits [ADDR_W-1:3] equal to those of the start address.
- R3: Length code 3'b011 gives a 16-word burst. Word i has address bits [3:0] equal to (start[3:0] + i) mod 16, and bits [ADDR_W-1:4] equal to those of the start address.
- R4: Every length code other than 3'b010 and 3'b011 behaves exactly like 3'b010.
- R5: `start_req` is sampled on a rising edge while the block is idle and `burst_en` is high. On that edge `burst_wait` goes high for exactly one cycle. The words then follow on consecutive cycles, and `burst_wait` is never high together with `data_valid`.
- R6: `data_valid` is high for exactly one cycle per issued word. `burst_done` is high for exactly the one cycle after the last word, with `data_valid` low.
- R7: `burst_en` low on a rising edge ends any burst. From that edge on, `data_valid`, `burst_wait` and `burst_done` are low, and a later request starts a fresh burst.
- R8: With the edge select bit at 0, outputs change just after the rising edge. With it at 1, the same values appear half a cycle later, after the following falling edge.
- R9: The length code is captured when a burst starts. A configuration write during a burst has no effect on that burst and applies to the next one.
- R10: `start_req` is ignored while a burst is in progress: the current burst runs to completion unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Loads the configuration fields on a rising edge |
| cfg_len_code | input | 3 | Burst-length code (010 = 8 words, 011 = 16 words, others = 8) |
| cfg_fall_edge | input | 1 | 1 = launch outputs on the falling edge |
| burst_en | input | 1 | Burst enable; low aborts and idles the sequencer |
| start_req | input | 1 | Requests a burst at `start_addr` |
| start_addr | input | ADDR_W | Word address of the first word |
| word_addr | output | ADDR_W | Address of the current burst word |
| data_valid | output | 1 | One pulse per issued word |
| burst_wait | output | 1 | High during the initial wait cycle |
| burst_done | output | 1 | Pulses after the last word |

## Verification
Every length code is swept against all sixteen start offsets, with a high address prefix, so that the wrap point, the held upper bits and the 8-versus-16 choice are each shown at every position. Separate runs cover several further patterns:
- a mid-burst configuration write, which separates a latched length from a live one;
- a request held high through a burst, which shows that restarts are ignored;
- an enable drop partway through a burst, which shows the abort;
- a falling-edge burst sampled a quarter and three quarters into each cycle, which tells the two launch edges apart.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

    localparam int OFF_W = 4;

    localparam logic [2:0] LEN_CODE_8  = 3'b010;
    localparam logic [2:0] LEN_CODE_16 = 3'b011;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRIME  = 2'd1,
        ST_STREAM = 2'd2,
        ST_FINISH = 2'd3
    } wbs_state_e;

    typedef struct packed {
        logic valid;
        logic hold;
        logic done;
    } wbs_flags_t;

    // Only the 16-word code widens the group; all others fall back to 8.
    function automatic logic code_is_16(input logic [2:0] code);
        return code == LEN_CODE_16;
    endfunction

    // Advance the offset inside the aligned group.
    function automatic logic [OFF_W-1:0] wrap_next(input logic [OFF_W-1:0] off,
                                                   input logic wide);
        logic [OFF_W-1:0] nxt;
        if (wide) nxt = off + 4'd1;
        else      nxt = {off[3], off[2:0] + 3'd1};
        return nxt;
    endfunction

    function automatic logic [OFF_W-1:0] last_index(input logic wide);
        return wide ? 4'd15 : 4'd7;
    endfunction

endpackage

// File: rtl/wbs_cfg_reg.sv
module wbs_cfg_reg
    import wbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_len_code,
    input  logic       cfg_fall_edge,
    output logic       len16,
    output logic       fall_sel
);

    logic [2:0] code_q;
    logic       fall_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= LEN_CODE_8;
            fall_q <= 1'b0;
        end else if (cfg_wr) begin
            code_q <= cfg_len_code;
            fall_q <= cfg_fall_edge;
        end
    end

    assign len16    = code_is_16(code_q);
    assign fall_sel = fall_q;

    // R1
    cfg_reset_default_chk: assert property (@(posedge clk)
        $past(rst) |-> (code_q == LEN_CODE_8 && !fall_q));

endmodule

// File: rtl/wbs_addr_core.sv
module wbs_addr_core
    import wbs_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_en,
    input  logic              start_req,
    input  logic              len16_cfg,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] addr_o,
    output wbs_flags_t        flags_o
);

    localparam int HI_W = ADDR_W - OFF_W;

    wbs_state_e        state_q;
    logic [HI_W-1:0]   hi_q;
    logic [OFF_W-1:0]  off_q;
    logic [OFF_W-1:0]  cnt_q;
    logic              wide_q;
    logic [ADDR_W-1:0] addr_q;
    wbs_flags_t        flags_q;
    logic [ADDR_W-1:0] word_now;

    assign word_now = {hi_q, off_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            hi_q    <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            flags_q <= '0;
        end else if (!burst_en) begin
            state_q <= ST_IDLE;
            flags_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    flags_q.done <= 1'b0;
                    if (start_req) begin
                        hi_q         <= start_addr[ADDR_W-1:OFF_W];
                        off_q        <= start_addr[OFF_W-1:0];
                        wide_q       <= len16_cfg;
                        flags_q.hold <= 1'b1;
                        state_q      <= ST_PRIME;
                    end
                end
                ST_PRIME: begin
                    flags_q.hold  <= 1'b0;
                    flags_q.valid <= 1'b1;
                    addr_q        <= word_now;
                    off_q         <= wrap_next(off_q, wide_q);
                    cnt_q         <= '0;
                    state_q       <= ST_STREAM;
                end
                ST_STREAM: begin
                    if (cnt_q == last_index(wide_q)) begin
                        flags_q.valid <= 1'b0;
                        flags_q.done  <= 1'b1;
                        state_q       <= ST_FINISH;
                    end else begin
                        addr_q <= word_now;
                        off_q  <= wrap_next(off_q, wide_q);
                        cnt_q  <= cnt_q + 4'd1;
                    end
                end
                ST_FINISH: begin
                    flags_q.done <= 1'b0;
                    state_q      <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign addr_o  = addr_q;
    assign flags_o = flags_q;

    // R5
    valid_wait_excl_chk: assert property (@(posedge clk) disable iff (rst)
        flags_q.valid |-> !flags_q.hold);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        flags_q.done |=> !flags_q.done);

    // R6
    done_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q.done) |-> $past(flags_q.valid));

    // R7
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !burst_en |=> (flags_q == '0));

    // R2
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.valid && $past(flags_q.valid))
            |-> addr_q[ADDR_W-1:OFF_W] == $past(addr_q[ADDR_W-1:OFF_W]));

    // R3
    wide_step_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.valid && $past(flags_q.valid) && wide_q)
            |-> addr_q[3:0] == $past(addr_q[3:0]) + 4'd1);

    // R10
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_q.valid && $past(flags_q.valid)) |-> $stable(wide_q));

endmodule

// File: rtl/wbs_edge_launch.sv
module wbs_edge_launch
    import wbs_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter bit EDGE_SEL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_sel,
    input  logic [ADDR_W-1:0] addr_i,
    input  wbs_flags_t        flags_i,
    output logic [ADDR_W-1:0] addr_o,
    output wbs_flags_t        flags_o
);

    generate
        if (EDGE_SEL_EN) begin : g_dual
            logic [ADDR_W-1:0] addr_n;
            wbs_flags_t        flags_n;

            always_ff @(negedge clk) begin
                if (rst) begin
                    addr_n  <= '0;
                    flags_n <= '0;
                end else begin
                    addr_n  <= addr_i;
                    flags_n <= flags_i;
                end
            end

            assign addr_o  = fall_sel ? addr_n  : addr_i;
            assign flags_o = fall_sel ? flags_n : flags_i;

            // R8
            fall_copy_chk: assert property (@(negedge clk) disable iff (rst)
                fall_sel |=> (flags_o == $past(flags_i)));
        end else begin : g_rise
            assign addr_o  = addr_i;
            assign flags_o = flags_i;
        end
    endgenerate

endmodule

// File: rtl/wrap_burst_seq.sv
module wrap_burst_seq
    import wbs_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter bit EDGE_SEL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [2:0]        cfg_len_code,
    input  logic              cfg_fall_edge,
    input  logic              burst_en,
    input  logic              start_req,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] word_addr,
    output logic              data_valid,
    output logic              burst_wait,
    output logic              burst_done
);

    logic              len16;
    logic              fall_sel;
    logic [ADDR_W-1:0] core_addr;
    wbs_flags_t        core_flags;
    wbs_flags_t        out_flags;

    wbs_cfg_reg u_cfg (
        .clk           (clk),
        .rst           (rst),
        .cfg_wr        (cfg_wr),
        .cfg_len_code  (cfg_len_code),
        .cfg_fall_edge (cfg_fall_edge),
        .len16         (len16),
        .fall_sel      (fall_sel)
    );

    wbs_addr_core #(.ADDR_W(ADDR_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .burst_en   (burst_en),
        .start_req  (start_req),
        .len16_cfg  (len16),
        .start_addr (start_addr),
        .addr_o     (core_addr),
        .flags_o    (core_flags)
    );

    wbs_edge_launch #(.ADDR_W(ADDR_W), .EDGE_SEL_EN(EDGE_SEL_EN)) u_launch (
        .clk      (clk),
        .rst      (rst),
        .fall_sel (fall_sel),
        .addr_i   (core_addr),
        .flags_i  (core_flags),
        .addr_o   (word_addr),
        .flags_o  (out_flags)
    );

    assign data_valid = out_flags.valid;
    assign burst_wait = out_flags.hold;
    assign burst_done = out_flags.done;

endmodule

// File: tb/tb_wrap_burst_seq.sv
module tb_wrap_burst_seq;

    localparam int  AW     = 24;
    localparam time CLK_P  = 40;
    localparam time QTR    = CLK_P / 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_wr;
    logic [2:0]    cfg_len_code;
    logic          cfg_fall_edge;
    logic          burst_en;
    logic          start_req;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] word_addr;
    logic          data_valid;
    logic          burst_wait;
    logic          burst_done;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    wrap_burst_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_len_code(cfg_len_code),
        .cfg_fall_edge(cfg_fall_edge), .burst_en(burst_en), .start_req(start_req),
        .start_addr(start_addr), .word_addr(word_addr), .data_valid(data_valid),
        .burst_wait(burst_wait), .burst_done(burst_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int len,
                                               input int i);
        int base;
        int off;
        base = int'(a) - (int'(a) % len);
        off  = ((int'(a) % len) + i) % len;
        return AW'(base + off);
    endfunction

    task automatic step();
        @(posedge clk);
        #QTR;
    endtask

    task automatic write_cfg(input logic [2:0] code, input logic fall);
        cfg_len_code  = code;
        cfg_fall_edge = fall;
        cfg_wr        = 1'b1;
        step();
        cfg_wr = 1'b0;
    endtask

    // Full rising-edge burst; mid_cfg writes code 010 during word 2, hold_start keeps the request high.
    task automatic run_burst(input logic [AW-1:0] a, input int len, input string req,
                             input bit mid_cfg, input bit hold_start);
        start_addr = a;
        start_req  = 1'b1;
        step();
        if (!hold_start) start_req = 1'b0;
        // R5 initial wait cycle
        chk(burst_wait == 1'b1 && data_valid == 1'b0, "R5", {burst_wait, data_valid}, 2'b10);
        for (int i = 0; i < len; i++) begin
            if (mid_cfg && i == 2) begin
                cfg_len_code = 3'b010; cfg_fall_edge = 1'b0; cfg_wr = 1'b1;
            end
            step();
            cfg_wr = 1'b0;
            chk(data_valid && !burst_wait && !burst_done, "R6", {data_valid, burst_wait, burst_done}, 3'b100);
            chk(word_addr == exp_addr(a, len, i), req, word_addr, exp_addr(a, len, i));
        end
        step();
        start_req = 1'b0;
        chk(burst_done && !data_valid, "R6", {burst_done, data_valid}, 2'b10);
        step();
        chk(!burst_done && !data_valid && !burst_wait, "R6", {burst_done, data_valid, burst_wait}, 3'b000);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_len_code = 3'b000; cfg_fall_edge = 1'b0;
        burst_en = 1'b0; start_req = 1'b0; start_addr = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        chk(word_addr == '0 && !data_valid && !burst_wait && !burst_done, "R1",
            {word_addr[7:0], data_valid, burst_wait, burst_done}, 0);
        burst_en = 1'b1;
        step();
        // R1 default config is an 8-word rising-edge burst
        run_burst(24'hABC00B, 8, "R1", 1'b0, 1'b0);

        // R2 R3 R4 sweep of every code and offset
        for (int code = 0; code < 8; code++) begin
            write_cfg(3'(code), 1'b0);
            for (int off = 0; off < 16; off++) begin
                if (code == 3) run_burst(24'h5A3C70 | AW'(off), 16, "R3", 1'b0, 1'b0);
                else if (code == 2) run_burst(24'h5A3C70 | AW'(off), 8, "R2", 1'b0, 1'b0);
                else run_burst(24'h5A3C70 | AW'(off), 8, "R4", 1'b0, 1'b0);
            end
        end

        // R9 config write mid-burst: current stays 16, next is 8
        write_cfg(3'b011, 1'b0);
        run_burst(24'h00123D, 16, "R9", 1'b1, 1'b0);
        run_burst(24'h00123D, 8, "R9", 1'b0, 1'b0);

        // R10 request held high during the burst
        write_cfg(3'b011, 1'b0);
        run_burst(24'hFFFFF9, 16, "R10", 1'b0, 1'b1);

        // R7 abort partway, then a fresh burst
        write_cfg(3'b010, 1'b0);
        start_addr = 24'h000406; start_req = 1'b1;
        step();
        start_req = 1'b0;
        repeat (3) step();
        chk(data_valid == 1'b1, "R7", data_valid, 1);
        burst_en = 1'b0;
        step();
        chk(!data_valid && !burst_wait && !burst_done, "R7", {data_valid, burst_wait, burst_done}, 0);
        step();
        chk(!data_valid && !burst_wait && !burst_done, "R7", {data_valid, burst_wait, burst_done}, 0);
        burst_en = 1'b1;
        step();
        run_burst(24'h000406, 8, "R7", 1'b0, 1'b0);

        // R8 falling-edge launch: values trail the rising-edge timing by half a cycle
        write_cfg(3'b010, 1'b1);
        start_addr = 24'h0CAFE5; start_req = 1'b1;
        step();
        start_req = 1'b0;
        chk(burst_wait == 1'b0, "R8", burst_wait, 0);
        #(2*QTR);
        chk(burst_wait == 1'b1, "R8", burst_wait, 1);
        for (int i = 0; i < 8; i++) begin
            step();
            if (i == 0) chk(data_valid == 1'b0, "R8", data_valid, 0);
            else chk(word_addr == exp_addr(24'h0CAFE5, 8, i-1), "R8", word_addr, exp_addr(24'h0CAFE5, 8, i-1));
            #(2*QTR);
            chk(data_valid && word_addr == exp_addr(24'h0CAFE5, 8, i), "R8", word_addr, exp_addr(24'h0CAFE5, 8, i));
        end
        step();
        #(2*QTR);
        chk(burst_done == 1'b1, "R8", burst_done, 1);
        step();
        write_cfg(3'b010, 1'b0);
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule